// File: doc/BRIEF.md
# Outbound Message Descriptor Queue Engine

This block runs the transmit side of a message unit. Transmit descriptors live in memory as a circular ring of 32-byte slots, and two byte-address pointers track the ring. Software owns the enqueue pointer and the hardware owns the dequeue pointer. Software writes a descriptor into the slot at the enqueue pointer. It then writes the mode register with the increment command bit set, and the enqueue pointer moves on one slot. The increment bit is a command and is never stored.

While the engine is enabled and the ring holds work, the engine reads three words of the descriptor at the dequeue pointer through a read port that allows one request at a time. Word 0 is the destination word, word 1 is the transfer size and word 2 is the source address. The engine presents these fields on a transmit-request port and holds them until the link side answers with done or error. A done answer retires the slot and sets end-of-message. An error answer halts the engine on the same slot until software acknowledges it.

Register select codes are 0 for mode, 1 for status, 2 for the dequeue pointer and 3 for the enqueue pointer. A pointer write forces bits 4:0 to zero.

Top module: `msgq_tx_engine`

## Requirements
- R1: After reset both pointers are 0, the mode readback is 0 and the status readback is 0x1 (only queue-empty set).
- R2: Mode bits 15:12 hold a size field f. The ring has 2^(f+1) entries, and any f above 10 is treated as 10 (2048 entries). Both pointers step by 32 bytes. Only the low log2(entries)+5 bits of a pointer change, so the pointer wraps inside a base aligned to the ring's size in bytes.
- R3: A mode write with bit 1 set advances the enqueue pointer by one slot when the ring is not full. The same write also loads enable (bit 0) and the size field. Bit 1 always reads back as 0.
- R4: Status bit 4 (queue full) is 1 when the next enqueue position equals the dequeue pointer. An increment command issued while the ring is full sets status bit 5 (overflow) and leaves the enqueue pointer unchanged.
- R5: Status bit 0 (queue empty) is 1 exactly when the two pointers are equal.
- R6: While enabled (mode bit 0), with status bit 7 clear and the ring not empty, the engine reads the words at deq, deq+4 and deq+8. It then drives tx_valid together with the destination ID (word 0 bits 31:16), the mailbox (word 0 bits 1:0), the size (word 1 bits 12:0) and the source (word 2). These outputs stay steady until tx_done or tx_err.
- R7: On tx_done the dequeue pointer advances one slot, with wrap, and status bit 1 (end-of-message) is set.
- R8: On tx_err status bit 7 (transmit error) is set and the dequeue pointer is unchanged. No read and no transmit request is made while bit 7 is set. Once bit 7 is cleared, the same descriptor is sent again.
- R9: A status write clears each of bits 7, 5 and 1 that is written as 1. Bits 0, 2 and 4 are not affected by the write.
- R10: With mode bit 0 clear, no descriptor is read or offered, and queued slots stay pending.
- R11: Status bit 2 (busy) is 1 while a descriptor is being read or offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 mode, 1 status, 2 deq, 3 enq) |
| reg_wdata | input | 32 | Register write data |
| mode_rd | output | 32 | Mode readback |
| status_rd | output | 32 | Status readback |
| enq_ptr | output | 32 | Enqueue pointer |
| deq_ptr | output | 32 | Dequeue pointer |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit request pending |
| tx_dest | output | 16 | Destination ID |
| tx_mbox | output | 2 | Mailbox number |
| tx_size | output | 13 | Transfer size in bytes |
| tx_src | output | 32 | Source buffer address |
| tx_done | input | 1 | Transmit completed |
| tx_err | input | 1 | Transmit failed |

## Verification
The bench fills a two-entry ring until it is full and then issues one more increment. A design that ignored the full condition would move the enqueue pointer onto the dequeue pointer, and the ring would then look empty. Wrap is checked on both pointers, and so is a size field above the legal range. A design without the clamp would carry the enqueue pointer out of its 64 KiB window. An error response is followed by a quiet window. A design that did not halt, or that advanced the dequeue pointer, would resend the descriptor or skip it. Status writes that target the live bits show whether the acknowledge is a true write-one-to-clear, and the disabled phase shows that the engine does not fetch.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
    localparam int DESC_BYTES = 32;
    localparam int BIT_TE     = 7;
    localparam int BIT_OVF    = 5;
    localparam int BIT_FULL   = 4;
    localparam int BIT_BUSY   = 2;
    localparam int BIT_EOM    = 1;
    localparam int BIT_EMPTY  = 0;
    localparam int MODE_EN    = 0;
    localparam int MODE_INC   = 1;
    localparam int MODE_F_LSB = 12;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_SEND} fetch_st_e;
endpackage

// File: rtl/msgq_ring_ptr.sv
module msgq_ring_ptr #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_val,
    input  logic             adv,
    input  logic [PTR_W-1:0] mask,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] ptr_nxt
);
    import msgq_pkg::*;

    logic [PTR_W-1:0] ptr_d;

    assign ptr_nxt = (ptr_q & ~mask) | ((ptr_q + PTR_W'(DESC_BYTES)) & mask);

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en)    ptr_d = {wr_val[PTR_W-1:5], 5'b0};
        else if (adv) ptr_d = ptr_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/msgq_fetch_fsm.sv
module msgq_fetch_fsm #(
    parameter int PTR_W  = 32,
    parameter int SIZE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              go,
    input  logic [PTR_W-1:0]  base,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [15:0]       tx_dest,
    output logic [1:0]        tx_mbox,
    output logic [SIZE_W-1:0] tx_size,
    output logic [PTR_W-1:0]  tx_src,
    input  logic              tx_done,
    input  logic              tx_err,
    output logic              done_o,
    output logic              err_o,
    output logic              busy_o
);
    import msgq_pkg::*;

    typedef struct packed {
        fetch_st_e         st;
        logic [1:0]        cnt;
        logic              pend;
        logic [15:0]       dest;
        logic [1:0]        mbox;
        logic [SIZE_W-1:0] size;
        logic [PTR_W-1:0]  src;
    } fsm_t;

    fsm_t s_d, s_q;
    logic unused_rdata;

    assign unused_rdata = ^mem_rdata;

    always_comb begin
        s_d     = s_q;
        mem_req = 1'b0;
        done_o  = 1'b0;
        err_o   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (go) begin
                    s_d.st   = ST_READ;
                    s_d.cnt  = 2'd0;
                    s_d.pend = 1'b0;
                end
            end
            ST_READ: begin
                if (!enable) begin
                    s_d.st = ST_IDLE;
                end else if (!s_q.pend) begin
                    mem_req  = 1'b1;
                    s_d.pend = 1'b1;
                end else if (mem_rvalid) begin
                    s_d.pend = 1'b0;
                    case (s_q.cnt)
                        2'd0: begin
                            s_d.dest = mem_rdata[31:16];
                            s_d.mbox = mem_rdata[1:0];
                        end
                        2'd1:    s_d.size = mem_rdata[SIZE_W-1:0];
                        default: s_d.src  = mem_rdata[PTR_W-1:0];
                    endcase
                    if (s_q.cnt == 2'd2) s_d.st = ST_SEND;
                    else                 s_d.cnt = s_q.cnt + 2'd1;
                end
            end
            ST_SEND: begin
                if (!enable) begin
                    s_d.st = ST_IDLE;
                end else if (tx_err) begin
                    s_d.st = ST_IDLE;
                    err_o  = 1'b1;
                end else if (tx_done) begin
                    s_d.st = ST_IDLE;
                    done_o = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign mem_addr = base + PTR_W'({s_q.cnt, 2'b00});
    assign tx_valid = (s_q.st == ST_SEND);
    assign tx_dest  = s_q.dest;
    assign tx_mbox  = s_q.mbox;
    assign tx_size  = s_q.size;
    assign tx_src   = s_q.src;
    assign busy_o   = (s_q.st != ST_IDLE);

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R6

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_done && !tx_err && enable) |=> (tx_valid && $stable(tx_dest) && $stable(tx_src) && $stable(tx_size))); // R6

    AST_BUSY_WITH_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid || mem_req) |-> busy_o); // R11
endmodule

// File: rtl/msgq_tx_engine.sv
module msgq_tx_engine #(
    parameter int PTR_W       = 32,
    parameter int MAX_ENTRIES = 2048,
    parameter int MAX_MSG     = 4096,
    localparam int SIZE_W     = $clog2(MAX_MSG) + 1,
    localparam int MAX_FIELD  = $clog2(MAX_ENTRIES) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       mode_rd,
    output logic [31:0]       status_rd,
    output logic [PTR_W-1:0]  enq_ptr,
    output logic [PTR_W-1:0]  deq_ptr,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [15:0]       tx_dest,
    output logic [1:0]        tx_mbox,
    output logic [SIZE_W-1:0] tx_size,
    output logic [PTR_W-1:0]  tx_src,
    input  logic              tx_done,
    input  logic              tx_err
);
    import msgq_pkg::*;

    typedef struct packed {
        logic       en;
        logic [3:0] fsz;
        logic       te;
        logic       ovf;
        logic       eom;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [3:0]       f_eff;
    logic [PTR_W-1:0] mask, enq_nxt, deq_nxt;
    logic             wr_mode, wr_stat, inc_cmd, full, empty;
    logic             done_p, err_p, busy, go;
    logic             unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[11:8], reg_wdata[6], reg_wdata[4:2], reg_wdata[0]};

    assign f_eff = (c_q.fsz > 4'(MAX_FIELD)) ? 4'(MAX_FIELD) : c_q.fsz;
    assign mask  = (PTR_W'(DESC_BYTES) << ({1'b0, f_eff} + 5'd1)) - PTR_W'(1);

    assign wr_mode = reg_we && (reg_sel == 2'd0);
    assign wr_stat = reg_we && (reg_sel == 2'd1);
    assign inc_cmd = wr_mode && reg_wdata[MODE_INC];
    assign empty   = (enq_ptr == deq_ptr);
    assign full    = (enq_nxt == deq_ptr);
    assign go      = c_q.en && !c_q.te && !empty;

    msgq_ring_ptr #(.PTR_W(PTR_W)) i_enq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we && (reg_sel == 2'd3)), .wr_val(reg_wdata[PTR_W-1:0]),
        .adv(inc_cmd && !full), .mask(mask),
        .ptr_q(enq_ptr), .ptr_nxt(enq_nxt)
    );

    msgq_ring_ptr #(.PTR_W(PTR_W)) i_deq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we && (reg_sel == 2'd2)), .wr_val(reg_wdata[PTR_W-1:0]),
        .adv(done_p), .mask(mask),
        .ptr_q(deq_ptr), .ptr_nxt(deq_nxt)
    );

    msgq_fetch_fsm #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .enable(c_q.en), .go(go), .base(deq_ptr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_dest(tx_dest), .tx_mbox(tx_mbox),
        .tx_size(tx_size), .tx_src(tx_src),
        .tx_done(tx_done), .tx_err(tx_err),
        .done_o(done_p), .err_o(err_p), .busy_o(busy)
    );

    always_comb begin
        c_d = c_q;
        if (wr_mode) begin
            c_d.en  = reg_wdata[MODE_EN];
            c_d.fsz = reg_wdata[MODE_F_LSB +: 4];
        end
        if (wr_stat) begin
            if (reg_wdata[BIT_TE])  c_d.te  = 1'b0;
            if (reg_wdata[BIT_OVF]) c_d.ovf = 1'b0;
            if (reg_wdata[BIT_EOM]) c_d.eom = 1'b0;
        end
        if (inc_cmd && full) c_d.ovf = 1'b1;
        if (done_p)          c_d.eom = 1'b1;
        if (err_p)           c_d.te  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mode_rd   = {16'b0, c_q.fsz, 11'b0, c_q.en};
    assign status_rd = {24'b0, c_q.te, 1'b0, c_q.ovf, full, 1'b0, busy, c_q.eom, empty};

    AST_FULL_KEEPS_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_cmd && full) |=> $stable(enq_ptr)); // R4

    AST_HALT_ON_TE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.te |-> (!mem_req && !tx_valid)); // R8

    AST_DEQ_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((deq_ptr != $past(deq_ptr)) && !$past(reg_we && (reg_sel == 2'd2))) |-> $past(tx_valid && tx_done)); // R7

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.en |-> !mem_req); // R10
endmodule

// File: tb/test_msgq_tx_engine.sv
module test_msgq_tx_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] mode_rd, status_rd, enq_ptr, deq_ptr, mem_addr, tx_src;
    logic        mem_req, tx_valid;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic [15:0] tx_dest;
    logic [1:0]  tx_mbox;
    logic [12:0] tx_size;
    logic        tx_done = 1'b0;
    logic        tx_err = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] mem [0:1023];

    logic [31:0] m_enq = 0, m_deq = 0, m_mask = 32'h3F;
    logic        m_te = 0, m_ovf = 0, m_eom = 0;
    bit          mon_on = 0;

    always #2 clk = ~clk;

    msgq_tx_engine i_msgq_tx_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mode_rd(mode_rd), .status_rd(status_rd),
        .enq_ptr(enq_ptr), .deq_ptr(deq_ptr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_dest(tx_dest), .tx_mbox(tx_mbox),
        .tx_size(tx_size), .tx_src(tx_src), .tx_done(tx_done), .tx_err(tx_err)
    );

    always @(posedge clk) begin
        if (!rst_n) mem_rvalid <= 1'b0;
        else        mem_rvalid <= mem_req;
        mem_rdata <= mem[mem_addr[11:2]];
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_next(logic [31:0] p);
        return (p & ~m_mask) | ((p + 32) & m_mask);
    endfunction

    function automatic logic [31:0] m_status();
        logic full = (m_next(m_enq) == m_deq);
        return {24'b0, m_te, 1'b0, m_ovf, full, 2'b0, m_eom, m_enq == m_deq};
    endfunction

    function automatic void set_mask(int f);
        int fe = (f > 10) ? 10 : f;
        m_mask = (32'd32 << (fe + 1)) - 1;
    endfunction

    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            check("R5 enq monitor", enq_ptr, m_enq);
            check("R7 deq monitor", deq_ptr, m_deq);
            check("R9 status monitor", status_rd & ~32'h4, m_status());
        end
    end

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        logic was_full = (m_next(m_enq) == m_deq);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            2'd0: begin
                if (data[1]) begin
                    if (was_full) m_ovf = 1;
                    else          m_enq = m_next(m_enq);
                end
                set_mask(int'(data[15:12]));
            end
            2'd1: begin
                if (data[7]) m_te = 0;
                if (data[5]) m_ovf = 0;
                if (data[1]) m_eom = 0;
            end
            2'd2: m_deq = {data[31:5], 5'b0};
            default: m_enq = {data[31:5], 5'b0};
        endcase
    endtask

    task automatic serve(int slot, bit err);
        int t = 0;
        while (!tx_valid && t < 300) begin @(negedge clk); t++; end
        check("R6 tx_valid seen", {31'b0, tx_valid}, 32'd1);
        check("R11 busy while offering", {31'b0, status_rd[2]}, 32'd1);
        check("R6 dest", {16'b0, tx_dest}, {16'b0, 16'hA000 | 16'(slot)});
        check("R6 mbox", {30'b0, tx_mbox}, 32'(slot & 3));
        check("R6 size", {19'b0, tx_size}, 32'(8 << slot));
        check("R6 src", tx_src, 32'h8000_0000 + 32'(slot * 256));
        if (err) tx_err = 1'b1; else tx_done = 1'b1;
        @(negedge clk);
        tx_err = 1'b0; tx_done = 1'b0;
        if (err) m_te = 1;
        else begin m_deq = m_next(m_deq); m_eom = 1; end
    endtask

    task automatic quiet(string req, int n);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_valid || mem_req) seen = 1;
        end
        check(req, {31'b0, seen}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int s = 0; s < 8; s++) begin
            mem[s*8 + 0] = {16'hA000 | 16'(s), 14'b0, 2'(s & 3)};
            mem[s*8 + 1] = 32'(8 << s);
            mem[s*8 + 2] = 32'h8000_0000 + 32'(s * 256);
        end
    end

    initial begin
        #200000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after reset", status_rd, 32'h1);
        check("R1 mode after reset", mode_rd, 32'h0);
        check("R1 enq after reset", enq_ptr, 32'h0);
        check("R1 deq after reset", deq_ptr, 32'h0);
        mon_on = 1;

        wr(2, 32'h1000); wr(3, 32'h1000);
        wr(0, 32'h0000);
        check("R5 empty on equal ptrs", status_rd, 32'h1);
        wr(0, 32'h0002);
        check("R3 enq advanced", enq_ptr, 32'h1020);
        check("R4 full two-entry ring", status_rd, 32'h10);
        check("R3 inc bit reads 0", mode_rd, 32'h0);
        wr(0, 32'h0002);
        check("R4 enq held when full", enq_ptr, 32'h1020);
        check("R4 overflow set", status_rd, 32'h30);
        wr(1, 32'h0000_0011);
        check("R9 live bits unaffected", status_rd, 32'h30);
        wr(1, 32'h20);
        check("R9 overflow cleared", status_rd, 32'h10);

        wr(0, 32'h1);
        serve(0, 0);
        @(negedge clk);
        check("R7 deq after done", deq_ptr, 32'h1020);
        check("R7 eom and empty", status_rd, 32'h3);
        wr(1, 32'h2);
        check("R9 eom cleared", status_rd, 32'h1);

        wr(0, 32'h3);
        check("R2 enq wraps", enq_ptr, 32'h1000);
        serve(1, 0);
        @(negedge clk);
        check("R2 deq wraps", deq_ptr, 32'h1000);
        wr(1, 32'h2);

        wr(0, 32'h2003); wr(0, 32'h2003); wr(0, 32'h2003);
        check("R3 three enqueued", enq_ptr, 32'h1060);
        serve(0, 0);
        serve(1, 1);
        check("R8 te set", status_rd[7], 1'b1);
        check("R8 deq unchanged", deq_ptr, 32'h1020);
        quiet("R8 halted while te", 20);
        wr(1, 32'h80);
        serve(1, 0);
        serve(2, 0);
        @(negedge clk);
        check("R7 deq after resume", deq_ptr, 32'h1060);
        wr(1, 32'h2);

        wr(0, 32'h2000);
        wr(0, 32'h2002);
        quiet("R10 no fetch when disabled", 20);
        check("R10 slot pending", deq_ptr, 32'h1060);
        wr(0, 32'h2001);
        serve(3, 0);
        @(negedge clk);
        check("R7 deq after enable", deq_ptr, 32'h1080);
        wr(1, 32'h2);

        wr(0, 32'hF000);
        wr(2, 32'h20); wr(3, 32'hFFE0);
        wr(0, 32'hF002);
        check("R2 field clamp wrap", enq_ptr, 32'h0);
        @(negedge clk);

        mon_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule